// File: doc/BRIEF.md
# Multi-Mode Timer with Reload

This block is a timer with a 16-bit up-counter, kept as a high byte and a low byte. Each byte can be read directly, and software can load either byte at any time. A run bit and a tick enable decide when the counter moves. The tick enable pulses once per machine cycle. A two-bit mode input sets how the counter is laid out and what happens when it rolls over:

- a 13-bit count made of the whole high byte and the five low bits of the low byte;
- a plain 16-bit count;
- an 8-bit count in the low byte that reloads itself from the high byte.

Every rollover sets an overflow flag, which drives one request line of an interrupt controller. The flag stays set until one of two things clears it: the controller's acknowledge, or a software write of the flag.

In the 13-bit and 16-bit modes the counter goes back to zero after a rollover, so software must reload the bytes if it wants a different start value. In the reload mode the hardware restores the low byte from the high byte on every rollover, so the counter repeats the same period with no help from software. A fourth mode code holds the counter still.

Top module: `tmr_core`

## Requirements
- R1: After reset, cnt_hi and cnt_lo are 0x00 and ovf_flag is 0.
- R2: The counter advances by one only on a clock edge where run=1 and tick=1. When run=0 or tick=0 the count keeps its value.
- R3: mode=1 selects a 16-bit counter {cnt_hi,cnt_lo}. The step from 0xFFFF goes to 0x0000 and sets ovf_flag.
- R4: mode=0 selects a 13-bit counter {cnt_hi, cnt_lo[4:0]}. cnt_lo[7:5] is never changed by counting. The step from the all-ones value goes to 0 in those 13 bits and sets ovf_flag.
- R5: mode=2 counts in cnt_lo alone and leaves cnt_hi unchanged. The step from cnt_lo=0xFF loads cnt_lo with cnt_hi and sets ovf_flag.
- R6: mode=3 holds the count. Ticks change neither byte and never set ovf_flag.
- R7: wr_hi or wr_lo loads wr_data into that byte at the next edge. On any edge with a byte write, the count does not advance in either byte and no rollover occurs.
- R8: ovf_flag goes to 1 on the same edge at which the count rolls over, and it stays 1 until it is cleared.
- R9: int_ack=1 clears ovf_flag, and flag_wr=1 loads ovf_flag with flag_wd. flag_wr wins over int_ack. A rollover on the same edge wins over both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable, one pulse per machine cycle |
| run | input | 1 | Run control; 0 freezes the count |
| mode | input | 2 | 0: 13-bit, 1: 16-bit, 2: 8-bit reload, 3: hold |
| wr_hi | input | 1 | Load the high byte from wr_data |
| wr_lo | input | 1 | Load the low byte from wr_data |
| wr_data | input | 8 | Data for byte loads |
| flag_wr | input | 1 | Software write of the overflow flag |
| flag_wd | input | 1 | Value for the software flag write |
| int_ack | input | 1 | Interrupt acknowledge; clears the flag |
| cnt_hi | output | 8 | Current high byte |
| cnt_lo | output | 8 | Current low byte |
| ovf_flag | output | 1 | Overflow flag, the interrupt request |

## Verification
Every result appears one clock edge after the inputs that cause it. Both bytes and the flag are registered and the path to them passes through no other register. This applies to a tick, a byte load, a rollover reload, a flag set and a flag clear alike. The bench drives its inputs on the falling edge. It advances its own behavioural model for the rising edge that follows, and compares the model with the outputs on the next falling edge. The directed checks therefore read the value exactly one edge after the stimulus.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_13B    = 2'd0,
    MODE_16B    = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_HOLD   = 2'd3
  } tmr_mode_e;

endpackage

// File: rtl/tmr_step.sv
module tmr_step
  import tmr_pkg::*;
#(
  parameter int BW    = 8,
  parameter int M0_LO = 5
) (
  input  logic [1:0]    mode,
  input  logic [BW-1:0] hi,
  input  logic [BW-1:0] lo,
  output logic [BW-1:0] nxt_hi,
  output logic [BW-1:0] nxt_lo,
  output logic          wrap,
  output logic          active
);

  localparam int FW   = 2 * BW;
  localparam int M0_W = BW + M0_LO;

  // full-width increment, carry in the top bit
  function automatic logic [FW:0] f_inc_full(logic [BW-1:0] h, logic [BW-1:0] l);
    return {1'b0, h, l} + {{FW{1'b0}}, 1'b1};
  endfunction

  // short-count increment over high byte plus low bits of the low byte
  function automatic logic [M0_W:0] f_inc_short(logic [BW-1:0] h, logic [BW-1:0] l);
    logic [M0_W-1:0] v;
    v = {h, l[M0_LO-1:0]};
    return {1'b0, v} + {{M0_W{1'b0}}, 1'b1};
  endfunction

  // single-byte increment, carry in the top bit
  function automatic logic [BW:0] f_inc_byte(logic [BW-1:0] l);
    return {1'b0, l} + {{BW{1'b0}}, 1'b1};
  endfunction

  tmr_mode_e       m;
  logic [FW:0]     r_full;
  logic [M0_W:0]   r_short;
  logic [BW:0]     r_byte;

  assign m       = tmr_mode_e'(mode);
  assign r_full  = f_inc_full(hi, lo);
  assign r_short = f_inc_short(hi, lo);
  assign r_byte  = f_inc_byte(lo);

  always_comb begin
    nxt_hi = hi;
    nxt_lo = lo;
    wrap   = 1'b0;
    active = 1'b1;
    case (m)
      MODE_13B: begin
        nxt_hi = r_short[M0_W-1:M0_LO];
        nxt_lo = {lo[BW-1:M0_LO], r_short[M0_LO-1:0]};
        wrap   = r_short[M0_W];
      end
      MODE_16B: begin
        nxt_hi = r_full[FW-1:BW];
        nxt_lo = r_full[BW-1:0];
        wrap   = r_full[FW];
      end
      MODE_RELOAD: begin
        wrap   = r_byte[BW];
        nxt_lo = r_byte[BW] ? hi : r_byte[BW-1:0];
      end
      default: begin
        active = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/tmr_byte_reg.sv
module tmr_byte_reg #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [BW-1:0] wd,
  input  logic          upd,
  input  logic [BW-1:0] nd,
  output logic [BW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (wr)  q <= wd;
    else if (upd) q <= nd;
  end

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic sw_wr,
  input  logic sw_data,
  input  logic ack,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag <= 1'b0;
    else if (set)   flag <= 1'b1;
    else if (sw_wr) flag <= sw_data;
    else if (ack)   flag <= 1'b0;
  end

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int BW    = 8,
  parameter int M0_LO = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic [1:0]    mode,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [BW-1:0] wr_data,
  input  logic          flag_wr,
  input  logic          flag_wd,
  input  logic          int_ack,
  output logic [BW-1:0] cnt_hi,
  output logic [BW-1:0] cnt_lo,
  output logic          ovf_flag
);

  localparam int NBYTE = 2;

  logic [BW-1:0] step_hi, step_lo;
  logic          step_wrap, step_active;
  logic          any_wr;
  logic          step_en;
  logic          roll_ev;

  logic [BW-1:0] byte_q   [NBYTE];
  logic [BW-1:0] byte_nd  [NBYTE];
  logic          byte_wr  [NBYTE];

  tmr_step #(.BW(BW), .M0_LO(M0_LO)) i_step (
    .mode   (mode),
    .hi     (cnt_hi),
    .lo     (cnt_lo),
    .nxt_hi (step_hi),
    .nxt_lo (step_lo),
    .wrap   (step_wrap),
    .active (step_active)
  );

  // a byte write blocks the increment of both bytes
  assign any_wr  = wr_hi | wr_lo;
  assign step_en = run & tick & step_active & ~any_wr;
  assign roll_ev = step_en & step_wrap;

  assign byte_nd[0] = step_lo;
  assign byte_nd[1] = step_hi;
  assign byte_wr[0] = wr_lo;
  assign byte_wr[1] = wr_hi;

  for (genvar g = 0; g < NBYTE; g++) begin : g_byte
    tmr_byte_reg #(.BW(BW)) i_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (byte_wr[g]),
      .wd    (wr_data),
      .upd   (step_en),
      .nd    (byte_nd[g]),
      .q     (byte_q[g])
    );
  end

  assign cnt_lo = byte_q[0];
  assign cnt_hi = byte_q[1];

  tmr_flag i_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (roll_ev),
    .sw_wr   (flag_wr),
    .sw_data (flag_wd),
    .ack     (int_ack),
    .flag    (ovf_flag)
  );

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int BW    = 8,
  parameter int M0_LO = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [1:0]    mode,
  input logic          wr_hi,
  input logic          wr_lo,
  input logic [BW-1:0] wr_data,
  input logic          flag_wr,
  input logic          flag_wd,
  input logic          int_ack,
  input logic [BW-1:0] cnt_hi,
  input logic [BW-1:0] cnt_lo,
  input logic          ovf_flag,
  input logic          roll_ev
);

  // R2
  run_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_hi && !wr_lo) |=> $stable({cnt_hi, cnt_lo}));

  // R3
  wrap16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (roll_ev && mode == 2'd1) |=> ({cnt_hi, cnt_lo} == '0));

  // R4
  wrap13_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (roll_ev && mode == 2'd0) |=> (cnt_hi == '0 && cnt_lo[M0_LO-1:0] == '0
      && cnt_lo[BW-1:M0_LO] == $past(cnt_lo[BW-1:M0_LO])));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (roll_ev && mode == 2'd2) |=> (cnt_lo == $past(cnt_hi) && $stable(cnt_hi)));

  // R6
  hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !wr_hi && !wr_lo) |=> $stable({cnt_hi, cnt_lo}));

  // R7
  load_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (cnt_lo == $past(wr_data)));

  // R7
  load_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (cnt_hi == $past(wr_data)));

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    roll_ev |=> ovf_flag);

  // R8
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(roll_ev) || $past(flag_wr && flag_wd)));

  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !roll_ev && !flag_wr) |=> !ovf_flag);

endmodule

bind tmr_core tmr_chk #(.BW(BW), .M0_LO(M0_LO)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .mode     (mode),
  .wr_hi    (wr_hi),
  .wr_lo    (wr_lo),
  .wr_data  (wr_data),
  .flag_wr  (flag_wr),
  .flag_wd  (flag_wd),
  .int_ack  (int_ack),
  .cnt_hi   (cnt_hi),
  .cnt_lo   (cnt_lo),
  .ovf_flag (ovf_flag),
  .roll_ev  (roll_ev)
);

// File: tb/test_tmr_core.sv
`timescale 1ns/1ps
module test_tmr_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       run = 1'b0;
  logic [1:0] mode = 2'd1;
  logic       wr_hi = 1'b0;
  logic       wr_lo = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       flag_wr = 1'b0;
  logic       flag_wd = 1'b0;
  logic       int_ack = 1'b0;
  logic [7:0] cnt_hi, cnt_lo;
  logic       ovf_flag;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  int m_hi = 0;
  int m_lo = 0;
  int m_flag = 0;

  always #2 clk = ~clk;

  tmr_core i_tmr_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .mode(mode),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .flag_wr(flag_wr), .flag_wd(flag_wd), .int_ack(int_ack),
    .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .ovf_flag(ovf_flag)
  );

  function automatic string tag_of(int md);
    case (md)
      0: return "R4";
      1: return "R3";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: advance the model for the coming edge, then compare
  task automatic cyc();
    int nh, nl, ovf, v, lo_top;
    nh = m_hi; nl = m_lo; ovf = 0;
    if (!rst_n) begin
      nh = 0; nl = 0;
    end else if (wr_hi || wr_lo) begin
      if (wr_hi) nh = wr_data;
      if (wr_lo) nl = wr_data;
    end else if (run && tick) begin
      case (mode)
        2'd0: begin
          lo_top = m_lo / 32;
          v = m_hi * 32 + (m_lo % 32) + 1;
          if (v == 8192) begin v = 0; ovf = 1; end
          nh = v / 32;
          nl = lo_top * 32 + (v % 32);
        end
        2'd1: begin
          v = m_hi * 256 + m_lo + 1;
          if (v == 65536) begin v = 0; ovf = 1; end
          nh = v / 256;
          nl = v % 256;
        end
        2'd2: begin
          if (m_lo == 255) begin nl = m_hi; ovf = 1; end
          else nl = m_lo + 1;
        end
        default: ;
      endcase
    end
    if (!rst_n) m_flag = 0;
    else if (ovf != 0) m_flag = 1;
    else if (flag_wr) m_flag = int'(flag_wd);
    else if (int_ack) m_flag = 0;
    m_hi = nh; m_lo = nl;
    @(posedge clk);
    @(negedge clk);
    check(tag_of(int'(mode)), int'(cnt_hi), m_hi);
    check(tag_of(int'(mode)), int'(cnt_lo), m_lo);
    check("R8", int'(ovf_flag), m_flag);
  endtask

  task automatic wr_byte(bit hi_sel, int val);
    wr_hi = hi_sel; wr_lo = !hi_sel; wr_data = 8'(val);
    cyc();
    wr_hi = 0; wr_lo = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(); cyc();
    // R1 reset state
    check("R1", int'(cnt_hi), 0);
    check("R1", int'(cnt_lo), 0);
    check("R1", int'(ovf_flag), 0);
    rst_n = 1;
    cyc();

    // R3 16-bit wrap
    mode = 2'd1;
    wr_byte(1, 8'hFF);
    wr_byte(0, 8'hFD);
    run = 1; tick = 1;
    cyc(); cyc();
    check("R3", int'(ovf_flag), 0);
    cyc();
    check("R3", int'({cnt_hi, cnt_lo}), 0);
    check("R8", int'(ovf_flag), 1);
    tick = 0; cyc();
    check("R8", int'(ovf_flag), 1);

    // R9 acknowledge clears
    int_ack = 1; cyc(); int_ack = 0;
    check("R9", int'(ovf_flag), 0);

    // R2 freeze by run and by tick
    tick = 1; cyc(); cyc();
    run = 0; repeat (5) cyc();
    check("R2", int'(cnt_lo), 2);
    run = 1; tick = 0; repeat (5) cyc();
    check("R2", int'(cnt_lo), 2);

    // R4 13-bit wrap keeps top low-byte bits
    mode = 2'd0;
    wr_byte(1, 8'hFF);
    wr_byte(0, 8'hFE);
    tick = 1; cyc();
    check("R4", int'(cnt_lo), 8'hFF);
    check("R4", int'(ovf_flag), 0);
    cyc();
    check("R4", int'(cnt_hi), 0);
    check("R4", int'(cnt_lo), 8'hE0);
    check("R4", int'(ovf_flag), 1);

    // R5 reload from high byte
    tick = 0; flag_wr = 1; flag_wd = 0; cyc(); flag_wr = 0;
    check("R9", int'(ovf_flag), 0);
    mode = 2'd2;
    wr_byte(1, 8'h40);
    wr_byte(0, 8'hFE);
    tick = 1; cyc(); cyc();
    check("R5", int'(cnt_lo), 8'h40);
    check("R5", int'(cnt_hi), 8'h40);
    check("R5", int'(ovf_flag), 1);
    cyc();
    check("R5", int'(cnt_lo), 8'h41);

    // R6 hold mode
    tick = 0; int_ack = 1; cyc(); int_ack = 0;
    mode = 2'd3; wr_byte(0, 8'hFF);
    tick = 1; repeat (10) cyc();
    check("R6", int'(cnt_lo), 8'hFF);
    check("R6", int'(ovf_flag), 0);

    // R7 write beats increment, other byte untouched
    mode = 2'd1; wr_byte(1, 8'h12); wr_byte(0, 8'h34);
    wr_lo = 1; wr_data = 8'h10; cyc(); wr_lo = 0;
    check("R7", int'(cnt_lo), 8'h10);
    check("R7", int'(cnt_hi), 8'h12);
    wr_lo = 1; wr_data = 8'hFF; cyc();
    wr_lo = 0; wr_hi = 1; wr_data = 8'hFF; cyc(); wr_hi = 0;
    check("R7", int'({cnt_hi, cnt_lo}), 16'hFFFF);
    check("R7", int'(ovf_flag), 0);

    // R9 rollover wins over acknowledge and write
    int_ack = 1; flag_wr = 1; flag_wd = 0; cyc(); int_ack = 0; flag_wr = 0;
    check("R9", int'(ovf_flag), 1);
    tick = 0; flag_wr = 1; flag_wd = 0; cyc();
    flag_wd = 1; int_ack = 1; cyc(); flag_wr = 0; int_ack = 0;
    check("R9", int'(ovf_flag), 1);

    // mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      if (i % 250 == 0) mode = 2'($urandom_range(0, 3));
      run     = ($urandom_range(0, 9) != 0);
      tick    = ($urandom_range(0, 9) < 7);
      wr_hi   = ($urandom_range(0, 99) < 2);
      wr_lo   = ($urandom_range(0, 99) < 2);
      wr_data = 8'($urandom_range(0, 255));
      flag_wr = ($urandom_range(0, 99) < 2);
      flag_wd = 1'($urandom_range(0, 1));
      int_ack = ($urandom_range(0, 99) < 5);
      cyc();
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule